// File: doc/BRIEF.md
# UART Error and Break Detector

This block holds the error-status logic of a UART receiver/transmitter pair. It watches the transmit-data write path, the receive-buffer load/read handshake, the stop-bit sample and the serial receive line. From these it raises three sticky flags: transmit collision, receive overrun and framing error. It also spots a line break, which is a long run of low bit samples. A break raises a framing error and parks the receiver in a hold state until the line goes high again.

The flags live in a register position that is shared with mode-select bits, and a bank-select input chooses which of the two the shared read port shows. Software clears each flag on its own by writing a 0 to its bit while the status bank is selected. A write of 1 leaves the flag unchanged. When a flag is set and cleared in the same cycle, the set wins. A transmit-data write that arrives while the transmitter is busy is blocked: the block removes the write enable, so the transmit buffer keeps its old byte.

Top module: `uart_err_det`

## Requirements
- R1: After reset all three flags, the break pulse and the receiver hold are 0. With bank_sel_i at 0, shared_o equals mode_i.
- R2: tbuf_we_o equals tbuf_wr_i in the same cycle, except while tx_busy_i is 1. A write while busy gives tbuf_we_o 0, and the collision flag reads 1 one cycle later.
- R3: A receive-buffer load while an earlier byte is still unread sets the overrun flag one cycle later. A load into an empty buffer does not set it. A load in the same cycle as a read does not set it either.
- R4: A stop strobe while rxd_i is 0 sets the framing flag one cycle later. A stop strobe while rxd_i is 1 does not.
- R5: On the 11th consecutive bit tick with rxd_i low, brk_o pulses high for one cycle, one cycle after that tick. In the same cycle the framing flag and rx_hold_o go to 1.
- R6: A bit tick with rxd_i high restarts the low count. The count saturates, so a low run of any length gives exactly one break pulse.
- R7: While rx_hold_o is 1, stop strobes do not affect the framing flag. rx_hold_o returns to 0 one cycle after rxd_i goes from 0 to 1.
- R8: Error-free traffic does not clear a set flag. This covers a stop strobe with rxd_i high, a load into an empty buffer and a write while idle.
- R9: With bank_sel_i at 1 and flag_wr_i at 1, each flag whose bit in flag_wdata_i is 0 is cleared one cycle later, and the others keep their value. A clear attempt while bank_sel_i is 0 has no effect. Bit positions are 0 for collision, 1 for overrun and 2 for framing.
- R10: When a flag is set and cleared in the same cycle, it reads 1 afterwards.
- R11: With bank_sel_i at 1, shared_o shows {framing, overrun, collision}, using the bit positions of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line |
| bit_tick_i | input | 1 | One-cycle strobe at each bit sample point |
| stop_stb_i | input | 1 | Stop-bit sample strobe |
| rbuf_load_i | input | 1 | Receive buffer loaded with a new byte |
| rbuf_read_i | input | 1 | Software read of the receive buffer |
| tx_busy_i | input | 1 | Transmission in progress |
| tbuf_wr_i | input | 1 | Software write to the transmit data register |
| bank_sel_i | input | 1 | 1 selects the status flags, 0 selects the mode bits |
| mode_i | input | 3 | Mode-select bits shown when bank_sel_i is 0 |
| flag_wr_i | input | 1 | Software write to the shared register |
| flag_wdata_i | input | 3 | Write data; a 0 bit clears the matching flag |
| tbuf_we_o | output | 1 | Qualified transmit-buffer write enable |
| txcol_o | output | 1 | Transmit collision flag |
| rxov_o | output | 1 | Receive overrun flag |
| fe_o | output | 1 | Framing error flag |
| brk_o | output | 1 | One-cycle break-detected pulse |
| rx_hold_o | output | 1 | Receiver held idle after a break |
| shared_o | output | 3 | Shared register read view |

## Verification
The write-enable gating is combinational, so the bench checks it in the same cycle, before the clock edge. Every flag, the break pulse and the hold state come from a single register stage and are due one cycle after the strobe that causes them. The bench applies each stimulus just after a rising edge, advances exactly one edge, and then samples. The collision, overrun, framing and set-versus-clear cases are swept over every combination of their inputs. Low runs from 1 to 13 ticks are swept, and the bench checks the pulse, hold and flag after every tick.

// File: rtl/uart_err_pkg.sv
package uart_err_pkg;
  localparam int unsigned NFLAG = 3;
  typedef enum int unsigned {
    F_COL = 0,
    F_OVR = 1,
    F_FRM = 2
  } flag_idx_e;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/uart_sticky_flags.sv
module uart_sticky_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_val_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q_o[k] <= 1'b0;
      else if (set_i[k])                    q_o[k] <= 1'b1;
      else if (clr_en_i && !clr_val_i[k])   q_o[k] <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && !(clr_en_i && !clr_val_i[k])) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det #(
  parameter int unsigned BRK_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic tick_i,
  output logic brk_hit_o,
  output logic brk_o,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(BRK_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BRK_BITS - 1);
  localparam logic [CW-1:0] SAT  = CW'(BRK_BITS);

  logic [CW-1:0] cnt_q;
  logic          rxd_q;
  logic          rise;

  assign rise      = rxd_i & ~rxd_q;
  assign brk_hit_o = tick_i & ~rxd_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_q <= 1'b1;
    else         rxd_q <= rxd_i;
  end

  // low-run counter, saturating so one break gives one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (rise)              cnt_q <= '0;
    else if (tick_i) begin
      if (rxd_i)                cnt_q <= '0;
      else if (cnt_q != SAT)    cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_o  <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      brk_o <= brk_hit_o;
      if (brk_hit_o)  hold_o <= 1'b1;
      else if (rise)  hold_o <= 1'b0;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT);
  p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |=> !brk_o);
  p_hold_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && rise) |=> !hold_o);
endmodule

// File: rtl/uart_err_det.sv
module uart_err_det
  import uart_err_pkg::*;
#(
  parameter int unsigned BRK_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       bit_tick_i,
  input  logic       stop_stb_i,
  input  logic       rbuf_load_i,
  input  logic       rbuf_read_i,
  input  logic       tx_busy_i,
  input  logic       tbuf_wr_i,
  input  logic       bank_sel_i,
  input  logic [2:0] mode_i,
  input  logic       flag_wr_i,
  input  logic [2:0] flag_wdata_i,
  output logic       tbuf_we_o,
  output logic       txcol_o,
  output logic       rxov_o,
  output logic       fe_o,
  output logic       brk_o,
  output logic       rx_hold_o,
  output logic [2:0] shared_o
);
  flag_vec_t set_v, flags;
  logic      rx_full_q;
  logic      brk_hit;

  uart_brk_det #(.BRK_BITS(BRK_BITS)) u_brk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rxd_i     (rxd_i),
    .tick_i    (bit_tick_i),
    .brk_hit_o (brk_hit),
    .brk_o     (brk_o),
    .hold_o    (rx_hold_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_full_q <= 1'b0;
    else         rx_full_q <= rbuf_load_i | (rx_full_q & ~rbuf_read_i);
  end

  assign tbuf_we_o    = tbuf_wr_i & ~tx_busy_i;
  assign set_v[F_COL] = tbuf_wr_i & tx_busy_i;
  assign set_v[F_OVR] = rbuf_load_i & rx_full_q & ~rbuf_read_i;
  assign set_v[F_FRM] = (stop_stb_i & ~rxd_i & ~rx_hold_o) | brk_hit;

  uart_sticky_flags #(.N(NFLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_v),
    .clr_en_i  (flag_wr_i & bank_sel_i),
    .clr_val_i (flag_wdata_i),
    .q_o       (flags)
  );

  assign txcol_o  = flags[F_COL];
  assign rxov_o   = flags[F_OVR];
  assign fe_o     = flags[F_FRM];
  assign shared_o = bank_sel_i ? flags : mode_i;

  p_col_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbuf_wr_i && tx_busy_i) |=> txcol_o);
  p_ovr_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbuf_load_i && rx_full_q && !rbuf_read_i) |=> rxov_o);
  p_brk_fe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (fe_o && rx_hold_o));
  p_clr_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !bank_sel_i) |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: tb/uart_err_det_test.sv
module uart_err_det_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rxd_i, bit_tick_i, stop_stb_i, rbuf_load_i, rbuf_read_i;
  logic tx_busy_i, tbuf_wr_i, bank_sel_i, flag_wr_i;
  logic [2:0] mode_i, flag_wdata_i, shared_o;
  logic tbuf_we_o, txcol_o, rxov_o, fe_o, brk_o, rx_hold_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  uart_err_det uut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    bit_tick_i = 0; stop_stb_i = 0; rbuf_load_i = 0; rbuf_read_i = 0;
    tx_busy_i = 0; tbuf_wr_i = 0; flag_wr_i = 0; flag_wdata_i = 3'b111;
  endtask

  task automatic flags3(output int v);
    v = {fe_o, rxov_o, txcol_o};
  endtask

  task automatic clr_all();
    bank_sel_i = 1; flag_wr_i = 1; flag_wdata_i = 3'b000; step(); idle();
    rbuf_read_i = 1; step(); idle();
  endtask

  task automatic set_all();
    tbuf_wr_i = 1; tx_busy_i = 1; stop_stb_i = 1; rxd_i = 0; rbuf_load_i = 1;
    step(); idle(); rxd_i = 1;
    rbuf_load_i = 1; step(); idle();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int f;
    idle(); rxd_i = 1; bank_sel_i = 0; mode_i = 3'b101;
    #(3*CLK_P); #1;
    // R1 reset state
    flags3(f);
    chk("R1 flags", f, 0);
    chk("R1 hold", rx_hold_o, 0);
    chk("R1 brk", brk_o, 0);
    chk("R1 shared mode", shared_o, 5);
    rst_ni = 1; step();

    // R2 collision sweep
    for (int v = 0; v < 4; v++) begin
      clr_all();
      tx_busy_i = v[1]; tbuf_wr_i = v[0];
      #1 chk("R2 we", tbuf_we_o, v[0] & ~v[1]);
      step(); idle();
      chk("R2 txcol", txcol_o, v[0] & v[1]);
    end

    // R3 overrun sweep: prior occupancy x load x read
    for (int v = 0; v < 8; v++) begin
      clr_all();
      if (v[2]) begin rbuf_load_i = 1; step(); idle(); end
      chk("R3 no ovr on fill", rxov_o, 0);
      rbuf_load_i = v[0]; rbuf_read_i = v[1]; step(); idle();
      chk("R3 rxov", rxov_o, v[2] & v[0] & ~v[1]);
    end

    // R4 framing sweep
    for (int v = 0; v < 4; v++) begin
      clr_all();
      stop_stb_i = v[0]; rxd_i = v[1]; step(); idle(); rxd_i = 1;
      chk("R4 fe", fe_o, v[0] & ~v[1]);
    end

    // R8 good traffic keeps flags
    clr_all(); set_all(); rbuf_read_i = 1; step(); idle();
    stop_stb_i = 1; step(); idle();
    rbuf_load_i = 1; step(); idle();
    tbuf_wr_i = 1; step(); idle();
    flags3(f); chk("R8 sticky", f, 7);

    // R9 clear with status bank deselected ignored; R11 view
    bank_sel_i = 0; flag_wr_i = 1; flag_wdata_i = 0; step(); idle();
    flags3(f); chk("R9 bank0 clear ignored", f, 7);
    chk("R11 mode view", shared_o, 5);
    bank_sel_i = 1; #1 chk("R11 status view", shared_o, 7);

    // R9/R10 exhaustive clear mask x set pattern
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 8; s++) begin
        clr_all(); set_all();
        bank_sel_i = 1; flag_wr_i = 1; flag_wdata_i = 3'(m);
        tbuf_wr_i = s[0]; tx_busy_i = s[0];
        rbuf_load_i = s[1];
        stop_stb_i = s[2]; rxd_i = ~s[2];
        step(); idle(); rxd_i = 1;
        flags3(f); chk("R9 R10 clear/set", f, m | s);
        chk("R11 shared", shared_o, m | s);
      end

    // R5/R6/R7 break sweep over low-run lengths
    for (int n = 1; n <= 13; n++) begin
      clr_all();
      rxd_i = 0; step();
      for (int i = 1; i <= n; i++) begin
        bit_tick_i = 1; step(); bit_tick_i = 0;
        chk("R5 R6 brk pulse", brk_o, int'(i == 11));
        chk("R5 hold", rx_hold_o, int'(i >= 11));
        chk("R5 fe", fe_o, int'(i >= 11));
      end
      if (n == 13) begin
        flag_wr_i = 1; flag_wdata_i = 3'b011; step(); idle();
        chk("R9 fe cleared", fe_o, 0);
        stop_stb_i = 1; step(); idle();
        chk("R7 stop ignored in hold", fe_o, 0);
      end
      rxd_i = 1; step();
      chk("R7 release", rx_hold_o, 0);
    end

    // R6 high sample restarts the count
    clr_all(); rxd_i = 0; step();
    for (int i = 0; i < 10; i++) begin bit_tick_i = 1; step(); bit_tick_i = 0; end
    rxd_i = 1; bit_tick_i = 1; step(); rxd_i = 0; bit_tick_i = 0; step();
    for (int i = 0; i < 10; i++) begin
      bit_tick_i = 1; step(); bit_tick_i = 0;
      chk("R6 restart no brk", brk_o, 0);
    end
    bit_tick_i = 1; step(); bit_tick_i = 0;
    chk("R6 brk after restart", brk_o, 1);
    rxd_i = 1; step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule